// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit processor with fixed 4-byte instructions fetches next. Each cycle it receives the address of the current instruction, a 3-bit class code saying what kind of control transfer the instruction is, the raw offset field of the instruction, and the index and value of one source register. From these it produces the next fetch address, a flag that says whether control left the straight-line path, and a request to write a return address into the link register.

The logic is purely combinational. Three pieces of it work side by side: an adder stage that forms the fall-through address and both PC-relative targets, a zero tester on the source operand, and a selector that picks among the candidates by class. Conditional branches test a single register against zero. The link-saving variants always target register 31. A source index of zero is treated as the hard-wired zero register, whatever value is on the data input.

Class codes: 0 = sequential, 1 = relative jump, 2 = relative jump with link, 3 = jump through register, 4 = jump through register with link, 5 = branch if zero, 6 = branch if nonzero, 7 = reserved (handled as sequential).

Top module: `npc_unit`

## Requirements
- R1: For class 0 or the reserved class 7, next_pc_o equals pc_i + 4, taken_o is 0 and link_we_o is 0.
- R2: For classes 1 and 2, next_pc_o equals pc_i + 4 plus all 26 bits of offset_i sign-extended from bit 25, and taken_o is 1.
- R3: For class 5 (branch if zero), taken_o is 1 exactly when the source operand is zero. The taken target is pc_i + 4 plus offset_i[15:0] sign-extended from bit 15, and offset_i[25:16] has no effect.
- R4: For class 6 (branch if nonzero), taken_o is 1 exactly when the source operand is nonzero, with the same 16-bit target as R3. When a branch of class 5 or 6 is not taken, next_pc_o equals pc_i + 4.
- R5: For classes 3 and 4, next_pc_o equals the source operand and taken_o is 1.
- R6: For classes 2 and 4, link_we_o is 1, link_rd_o is 31 and link_data_o is pc_i + 4. For every other class, link_we_o is 0.
- R7: When src_idx_i is 0, the source operand is zero whatever src_val_i holds: class 5 is always taken, class 6 is never taken, and classes 3 and 4 go to address 0.
- R8: All target and fall-through sums wrap modulo 2^32.
- R9: For class 4 with src_idx_i equal to 31, next_pc_o is the incoming src_val_i (the old register value) while link_data_o is pc_i + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| class_i | input | 3 | Control-transfer class code |
| offset_i | input | 26 | Raw offset field; branches use bits 15:0 |
| src_idx_i | input | 5 | Index of the source register |
| src_val_i | input | 32 | Value read for the source register |
| next_pc_o | output | 32 | Next fetch address |
| taken_o | output | 1 | Control left the sequential path |
| link_we_o | output | 1 | Return-address write request |
| link_rd_o | output | 5 | Destination register of the link write |
| link_data_o | output | 32 | Return address to write |

## Verification
The hardest cases to reach are the ones where two rules meet: a register jump with link whose source is register 31, a branch whose source index is zero while the data input carries a nonzero value, and targets that cross the top or bottom of the address space. The sweep crosses every class code with program counters next to both address ends, offsets at the extreme positive and negative values with junk in the unused upper bits, and source indices 0, 1 and 31 against zero, one, sign-bit and all-ones data. So each of those meeting points comes up many times.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN       = 32;
  localparam int JOFF_W     = 26;
  localparam int BOFF_W     = 16;
  localparam int RIDX_W     = 5;
  localparam int CLS_W      = 3;
  localparam int INSN_BYTES = 4;
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(31);

  typedef enum logic [CLS_W-1:0] {
    CLS_SEQ  = 3'd0,
    CLS_JMP  = 3'd1,
    CLS_JAL  = 3'd2,
    CLS_JR   = 3'd3,
    CLS_JALR = 3'd4,
    CLS_BEQZ = 3'd5,
    CLS_BNEZ = 3'd6,
    CLS_RSVD = 3'd7
  } npc_class_e;
endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import npc_pkg::*;
#(
  parameter int AW    = XLEN,
  parameter int JW    = JOFF_W,
  parameter int BW    = BOFF_W,
  parameter int STEP  = INSN_BYTES
) (
  input  logic [AW-1:0] pc_i,
  input  logic [JW-1:0] offset_i,
  output logic [AW-1:0] seq_pc_o,
  output logic [AW-1:0] jmp_tgt_o,
  output logic [AW-1:0] br_tgt_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] jmp_ext;
  logic [AW-1:0] br_ext;

  always_comb begin
    jmp_ext   = {{(AW-JW){offset_i[JW-1]}}, offset_i};
    br_ext    = {{(AW-BW){offset_i[BW-1]}}, offset_i[BW-1:0]};
    seq_pc_o  = pc_i + STEP_V;
    jmp_tgt_o = seq_pc_o + jmp_ext;
    br_tgt_o  = seq_pc_o + br_ext;
  end
endmodule

// File: rtl/npc_operand.sv
module npc_operand
  import npc_pkg::*;
#(
  parameter int AW = XLEN,
  parameter int IW = RIDX_W
) (
  input  logic [IW-1:0] src_idx_i,
  input  logic [AW-1:0] src_val_i,
  output logic [AW-1:0] opnd_o,
  output logic          is_zero_o
);
  always_comb begin
    opnd_o    = (src_idx_i == '0) ? '0 : src_val_i;
    is_zero_o = (opnd_o == '0);
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int AW = XLEN
) (
  input  logic [CLS_W-1:0] class_i,
  input  logic [AW-1:0]    seq_pc_i,
  input  logic [AW-1:0]    jmp_tgt_i,
  input  logic [AW-1:0]    br_tgt_i,
  input  logic [AW-1:0]    reg_tgt_i,
  input  logic             is_zero_i,
  output logic [AW-1:0]    next_pc_o,
  output logic             taken_o,
  output logic             link_we_o
);
  npc_class_e cls;

  always_comb begin
    cls       = npc_class_e'(class_i);
    next_pc_o = seq_pc_i;
    taken_o   = 1'b0;
    link_we_o = 1'b0;
    unique case (cls)
      CLS_JMP:  begin next_pc_o = jmp_tgt_i; taken_o = 1'b1; end
      CLS_JAL:  begin next_pc_o = jmp_tgt_i; taken_o = 1'b1; link_we_o = 1'b1; end
      CLS_JR:   begin next_pc_o = reg_tgt_i; taken_o = 1'b1; end
      CLS_JALR: begin next_pc_o = reg_tgt_i; taken_o = 1'b1; link_we_o = 1'b1; end
      CLS_BEQZ: begin
        taken_o = is_zero_i;
        if (is_zero_i) next_pc_o = br_tgt_i;
      end
      CLS_BNEZ: begin
        taken_o = !is_zero_i;
        if (!is_zero_i) next_pc_o = br_tgt_i;
      end
      CLS_SEQ, CLS_RSVD: begin end
      default: begin end
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
(
  input  logic [XLEN-1:0]   pc_i,
  input  logic [CLS_W-1:0]  class_i,
  input  logic [JOFF_W-1:0] offset_i,
  input  logic [RIDX_W-1:0] src_idx_i,
  input  logic [XLEN-1:0]   src_val_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_rd_o,
  output logic [XLEN-1:0]   link_data_o
);
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] jmp_tgt;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] opnd;
  logic            opnd_zero;

  npc_target_gen #(.AW(XLEN), .JW(JOFF_W), .BW(BOFF_W), .STEP(INSN_BYTES)) tgt_i (
    .pc_i      (pc_i),
    .offset_i  (offset_i),
    .seq_pc_o  (seq_pc),
    .jmp_tgt_o (jmp_tgt),
    .br_tgt_o  (br_tgt)
  );

  npc_operand #(.AW(XLEN), .IW(RIDX_W)) opnd_i (
    .src_idx_i (src_idx_i),
    .src_val_i (src_val_i),
    .opnd_o    (opnd),
    .is_zero_o (opnd_zero)
  );

  npc_select #(.AW(XLEN)) sel_i (
    .class_i   (class_i),
    .seq_pc_i  (seq_pc),
    .jmp_tgt_i (jmp_tgt),
    .br_tgt_i  (br_tgt),
    .reg_tgt_i (opnd),
    .is_zero_i (opnd_zero),
    .next_pc_o (next_pc_o),
    .taken_o   (taken_o),
    .link_we_o (link_we_o)
  );

  assign link_rd_o   = LINK_REG;
  assign link_data_o = seq_pc;

  always_comb begin
    if (!$isunknown({pc_i, class_i, src_idx_i, src_val_i, offset_i})) begin
      // R1 R4
      not_taken_falls_through_chk: assert (taken_o || next_pc_o == pc_i + XLEN'(INSN_BYTES))
        else $error("not-taken path left the sequential address");
      // R6
      link_fields_chk: assert (!link_we_o || (link_rd_o == 5'd31 && link_data_o == pc_i + 32'd4))
        else $error("link write with wrong register or data");
      // R2 R5
      uncond_taken_chk: assert (!(class_i inside {3'd1, 3'd2, 3'd3, 3'd4}) || taken_o)
        else $error("unconditional transfer not flagged taken");
      // R7
      zero_reg_branch_chk: assert (src_idx_i != '0 ||
                                   (class_i != 3'd5 || taken_o) && (class_i != 3'd6 || !taken_o))
        else $error("branch on the zero register misjudged");
      // R6
      link_class_chk: assert (link_we_o == (class_i == 3'd2 || class_i == 3'd4))
        else $error("link write for wrong class");
    end
  end
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [31:0] pc;
  logic [2:0]  cls;
  logic [25:0] off;
  logic [4:0]  sidx;
  logic [31:0] sval;
  logic [31:0] next_pc;
  logic        taken;
  logic        link_we;
  logic [4:0]  link_rd;
  logic [31:0] link_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  npc_unit dut_i (
    .pc_i(pc), .class_i(cls), .offset_i(off), .src_idx_i(sidx), .src_val_i(sval),
    .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
    .link_rd_o(link_rd), .link_data_o(link_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s class=%0d pc=%h off=%h idx=%0d val=%h : got %h expected %h",
               req, cls, pc, off, sidx, sval, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_pc(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFC;
      2: return 32'h0000_1000;
      3: return 32'h7FFF_FFF8;
      default: return 32'h8000_0010;
    endcase
  endfunction

  function automatic logic [25:0] pick_off(int i);
    case (i)
      0: return 26'h000_0000;
      1: return 26'h1FF_FFFF;
      2: return 26'h200_0000;
      3: return 26'h3FF_FFFC;
      4: return 26'h2A5_7FFF;
      default: return 26'h15A_8000;
    endcase
  endfunction

  function automatic logic [4:0] pick_idx(int i);
    case (i)
      0: return 5'd0;
      1: return 5'd1;
      default: return 5'd31;
    endcase
  endfunction

  function automatic logic [31:0] pick_val(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h8000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic check_vector();
    longint      p4;
    logic [31:0] seq, jt, bt, opnd, e_next;
    logic        e_taken, e_lwe;
    string       tag;
    p4   = longint'(pc) + 4;
    seq  = p4[31:0];
    jt   = 32'(p4 + longint'($signed(off)));
    bt   = 32'(p4 + longint'($signed(off[15:0])));
    opnd = (sidx == 5'd0) ? 32'd0 : sval;
    e_lwe = 1'b0;
    case (cls)
      3'd1: begin e_next = jt; e_taken = 1'b1; tag = "R2"; end
      3'd2: begin e_next = jt; e_taken = 1'b1; e_lwe = 1'b1; tag = "R2/R6"; end
      3'd3: begin e_next = opnd; e_taken = 1'b1; tag = (sidx == 0) ? "R5/R7" : "R5"; end
      3'd4: begin
        e_next = opnd; e_taken = 1'b1; e_lwe = 1'b1;
        tag = (sidx == 5'd31) ? "R9" : "R5/R6";
      end
      3'd5: begin
        e_taken = (opnd == 0); e_next = e_taken ? bt : seq;
        tag = (sidx == 0) ? "R3/R7" : "R3";
      end
      3'd6: begin
        e_taken = (opnd != 0); e_next = e_taken ? bt : seq;
        tag = (sidx == 0) ? "R4/R7" : "R4";
      end
      default: begin e_next = seq; e_taken = 1'b0; tag = "R1"; end
    endcase
    if (pc == 32'hFFFF_FFFC || pc == 32'h0) tag = {tag, "/R8"};
    chk({tag, " next_pc"}, next_pc, e_next);
    chk({tag, " taken"}, 32'(taken), 32'(e_taken));
    chk("R6 link_we", 32'(link_we), 32'(e_lwe));
    if (e_lwe) begin
      chk("R6 link_rd", 32'(link_rd), 32'd31);
      chk("R6 link_data", link_data, seq);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    pc = '0; cls = '0; off = '0; sidx = '0; sval = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: all-zero inputs give the sequential address
    chk("R1 initial next_pc", next_pc, 32'd4);
    chk("R1 initial taken", 32'(taken), 32'd0);
    for (int c = 0; c < 8; c++)
      for (int p = 0; p < 5; p++)
        for (int o = 0; o < 6; o++)
          for (int i = 0; i < 3; i++)
            for (int v = 0; v < 4; v++) begin
              @(posedge clk); #1;
              cls = 3'(c); pc = pick_pc(p); off = pick_off(o);
              sidx = pick_idx(i); sval = pick_val(v);
              @(negedge clk);
              check_vector();
            end
    // R8: branch wrap across the top of the address space
    @(posedge clk); #1;
    cls = 3'd5; pc = 32'hFFFF_FFF0; off = 26'h000_0020; sidx = 5'd3; sval = 32'd0;
    @(negedge clk);
    chk("R8 wrap up", next_pc, 32'h0000_0014);
    // R8: jump wrap below zero
    @(posedge clk); #1;
    cls = 3'd1; pc = 32'h0000_0008; off = 26'h3FF_FFF0;
    @(negedge clk);
    chk("R8 wrap down", next_pc, 32'hFFFF_FFFC);
    // R9: register jump with link through register 31 uses the old value
    @(posedge clk); #1;
    cls = 3'd4; pc = 32'h0000_4000; sidx = 5'd31; sval = 32'h0000_1230;
    @(negedge clk);
    chk("R9 target", next_pc, 32'h0000_1230);
    chk("R9 link data", link_data, 32'h0000_4004);
    // R3: upper offset bits have no effect on a branch
    @(posedge clk); #1;
    cls = 3'd5; pc = 32'h0000_0100; off = 26'h3FF_0010; sidx = 5'd0; sval = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R3 upper bits ignored", next_pc, 32'h0000_0114);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule